// File: doc/BRIEF.md
# PCM Serial Port with Automatic Frame-Sync Detection

This block is the digital serial side of a voice codec. Once per 8 kHz frame it moves one 16-bit word each way between a serial bus and a parallel 14-bit sample interface. The serial bus has a bit clock, a frame-sync strobe, a transmit data line with an output enable, and a receive data line. The word is two's complement and sent MSB first. Only its upper 14 bits carry the sample, and the word always occupies the first slot after the sync strobe, whether the frame holds 32 or 64 bit clocks.

Each frame the port measures how long frame sync stays high, counted on bit-clock falling edges. From that it decides whether the frame uses the long-sync or the short-sync format, and it reports the result on a status output. Receive data is aligned using the current frame's measurement. Transmit data must start before that measurement is complete, so the transmit launch uses the format measured in the previous frame. No word is sent until one frame has been measured. A mute input forces the receive sample to zero. It also blanks the transmit line, but only from the next frame boundary. The port runs on a fast system clock. It samples the bit clock, frame sync, receive data and mute as synchronous inputs and derives the bit-clock edges from them.

Top module: `pcm_serial_port`

## Requirements
- R1: A frame starts at a bit-clock falling edge where frame sync is sampled high after being sampled low at the previous falling edge. If frame sync is still high at the next falling edge, the frame is long format (`fmt_long`=1); otherwise it is short format (`fmt_long`=0). `fmt_known` goes high after the first measured frame and stays high. The status is re-measured every frame.
- R2: Receive bits are sampled on bit-clock falling edges. In long format the MSB is taken at the frame-start falling edge; in short format it is taken at the next falling edge. `rx_sample` carries word bits 15..2 (word bit 15 in `rx_sample[13]`), and the two lowest received bits are discarded. `rx_valid` pulses for one clock, once per frame, after the 14th bit has been captured.
- R3: `tx_sample` is latched when a frame-sync rising edge is seen, and `tx_take` pulses for one clock at that moment. The transmitted word is `{tx_sample, 2'b00}`, MSB first, with a new bit on each bit-clock rising edge. Changes to `tx_sample` after the latch do not affect the word.
- R4: The first transmitted bit appears as follows. With long format predicted, it appears at the frame-sync rising edge if the bit clock is already high, and otherwise at the next bit-clock rising edge. With short format predicted, it appears at the first bit-clock rising edge after the frame-start falling edge. The prediction is the format measured in the previous frame.
- R5: `tx_oe` is high for exactly 16 bit periods per frame and low at all other times. It stays low in any frame that starts while `fmt_known` is 0.
- R6: `mute_n` is sampled at the frame-sync rising edge. If it is low there, `tx_oe` stays low for that whole frame. A change of `mute_n` while a word is going out does not cut the word short.
- R7: While `mute_n` is low, each `rx_valid` pulse carries `rx_sample` = 14'h0000.
- R8: A sync pulse that stays high far past the word is treated as long format. The frame still transfers exactly 16 bits each way and produces one `rx_valid` pulse.
- R9: Frames of 32 and 64 bit clocks both work. Receive bits outside the first slot are ignored.
- R10: After reset, `tx_oe`, `tx_take`, `rx_valid` and `fmt_known` are 0, and `tx_oe` stays 0 while bit clocks run with frame sync low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, synchronous to clk |
| fsync | input | 1 | Frame-sync strobe |
| rx_din | input | 1 | Serial receive data |
| mute_n | input | 1 | Active-low mute for both paths |
| tx_sample | input | SAMPLE_W | Parallel sample to transmit |
| tx_take | output | 1 | One-clock pulse when tx_sample is latched |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for the transmit line (low = high impedance) |
| rx_sample | output | SAMPLE_W | Received parallel sample |
| rx_valid | output | 1 | One-clock pulse qualifying rx_sample |
| fmt_long | output | 1 | 1 = last measured frame was long format |
| fmt_known | output | 1 | A frame format has been measured since reset |

## Verification
The bench feeds sync edges in both halves of the bit-clock cycle. This exercises all four transmit launch points. A design that took its launch from the current frame, or ignored the bit-clock level at the sync edge, would shift the whole transmit word one bit period early or late. The bench also follows a long frame with a short one, so the receive alignment and the transmit prediction disagree. A design that used one format for both paths would corrupt one of the two words. Mute is dropped in the middle of a word and before a frame start, which separates a design that cuts the word short from one that fails to blank the next frame. A sync pulse held high for most of the frame checks that the bit counter stops after 16 bits instead of restarting.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } pcm_fmt_e;

    typedef struct packed {
        logic bclk_q;
        logic bclk_qq;
        logic fs_q;
        logic fs_qq;
        logic rx_q;
        logic rx_qq;
        logic mute_q;
    } pcm_sync_t;

endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic rx_din,
    input  logic mute_n,
    output logic b_rise,
    output logic b_fall,
    output logic b_high,
    output logic fs_rise,
    output logic fs_smp,
    output logic rx_smp,
    output logic mute_ok
);
    import pcm_port_pkg::*;

    pcm_sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.bclk_q  = bclk;
        s_d.bclk_qq = s_q.bclk_q;
        s_d.fs_q    = fsync;
        s_d.fs_qq   = s_q.fs_q;
        s_d.rx_q    = rx_din;
        s_d.rx_qq   = s_q.rx_q;
        s_d.mute_q  = mute_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // fs and rx are taken from the stage aligned with the old bit-clock level,
    // so a falling edge sees the values held just before it.
    assign b_rise  = s_q.bclk_q & ~s_q.bclk_qq;
    assign b_fall  = ~s_q.bclk_q & s_q.bclk_qq;
    assign b_high  = s_q.bclk_q;
    assign fs_rise = s_q.fs_q & ~s_q.fs_qq;
    assign fs_smp  = s_q.fs_qq;
    assign rx_smp  = s_q.rx_qq;
    assign mute_ok = s_q.mute_q;

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
    parameter int SAMPLE_W = 14,
    parameter int WORD_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     b_fall,
    input  logic                     fs_smp,
    input  logic                     rx_smp,
    input  logic                     mute_ok,
    output logic [SAMPLE_W-1:0]      rx_sample,
    output logic                     rx_valid,
    output pcm_port_pkg::pcm_fmt_e   fmt,
    output logic                     fmt_known
);
    import pcm_port_pkg::*;

    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(SAMPLE_W - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(SAMPLE_W);
    localparam logic [CW-1:0] CNT_MAX    = CW'(WORD_W);

    typedef struct packed {
        logic                prev_fs;
        logic                act;
        logic [CW-1:0]       cnt;
        logic [SAMPLE_W-1:0] sreg;
        pcm_fmt_e            fmt;
        logic                known;
        logic                valid;
        logic [SAMPLE_W-1:0] data;
    } rx_state_t;

    rx_state_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (b_fall) begin
            r_d.prev_fs = fs_smp;
            r_d.sreg    = {r_q.sreg[SAMPLE_W-2:0], rx_smp};
            if (fs_smp && !r_q.prev_fs) begin
                r_d.act = 1'b1;
                r_d.cnt = '0;
            end else if (r_q.act) begin
                if (r_q.cnt != CNT_MAX) r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == '0) begin
                    r_d.fmt   = fs_smp ? FMT_LONG : FMT_SHORT;
                    r_d.known = 1'b1;
                end
                if (r_d.cnt == ((r_d.fmt == FMT_LONG) ? LAST_LONG : LAST_SHORT)) begin
                    r_d.valid = 1'b1;
                    r_d.data  = mute_ok ? r_d.sreg : '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_sample = r_q.data;
    assign rx_valid  = r_q.valid;
    assign fmt       = r_q.fmt;
    assign fmt_known = r_q.known;

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
    parameter int SAMPLE_W = 14,
    parameter int WORD_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   b_rise,
    input  logic                   b_high,
    input  logic                   fs_rise,
    input  logic                   mute_ok,
    input  logic                   known,
    input  pcm_port_pkg::pcm_fmt_e fmt,
    input  logic [SAMPLE_W-1:0]    tx_sample,
    output logic                   tx_take,
    output logic                   tx_dout,
    output logic                   tx_oe
);
    import pcm_port_pkg::*;

    localparam int CW  = $clog2(WORD_W + 1);
    localparam int PAD = WORD_W - SAMPLE_W;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [1:0]        pend;
        logic              oe;
        logic [CW-1:0]     sent;
        logic              take;
    } tx_state_t;

    tx_state_t  t_d, t_q;
    logic [1:0] lead;

    always_comb begin
        t_d      = t_q;
        t_d.take = 1'b0;
        lead     = 2'(fmt == FMT_SHORT) + 2'(!b_high);
        if (fs_rise) begin
            t_d.shreg = {tx_sample, {PAD{1'b0}}};
            t_d.take  = 1'b1;
            t_d.oe    = 1'b0;
            t_d.pend  = '0;
            t_d.sent  = '0;
            if (known && mute_ok) begin
                if (lead == 2'd0) begin
                    t_d.oe   = 1'b1;
                    t_d.sent = CW'(1);
                end else begin
                    t_d.pend = lead;
                end
            end
        end else if (b_rise) begin
            if (t_q.pend != 2'd0) begin
                t_d.pend = t_q.pend - 2'd1;
                if (t_q.pend == 2'd1) begin
                    t_d.oe   = 1'b1;
                    t_d.sent = CW'(1);
                end
            end else if (t_q.oe) begin
                if (t_q.sent == CW'(WORD_W)) begin
                    t_d.oe = 1'b0;
                end else begin
                    t_d.shreg = {t_q.shreg[WORD_W-2:0], 1'b0};
                    t_d.sent  = t_q.sent + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tx_take = t_q.take;
    assign tx_oe   = t_q.oe;
    assign tx_dout = t_q.oe & t_q.shreg[WORD_W-1];

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int SAMPLE_W = 14,
    parameter int WORD_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                fsync,
    input  logic                rx_din,
    input  logic                mute_n,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                tx_take,
    output logic                tx_dout,
    output logic                tx_oe,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid,
    output logic                fmt_long,
    output logic                fmt_known
);
    import pcm_port_pkg::*;

    logic     b_rise, b_fall, b_high, fs_rise, fs_smp, rx_smp, mute_ok;
    pcm_fmt_e fmt;

    pcm_pin_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk    (bclk),
        .fsync   (fsync),
        .rx_din  (rx_din),
        .mute_n  (mute_n),
        .b_rise  (b_rise),
        .b_fall  (b_fall),
        .b_high  (b_high),
        .fs_rise (fs_rise),
        .fs_smp  (fs_smp),
        .rx_smp  (rx_smp),
        .mute_ok (mute_ok)
    );

    pcm_rx_deser #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .b_fall    (b_fall),
        .fs_smp    (fs_smp),
        .rx_smp    (rx_smp),
        .mute_ok   (mute_ok),
        .rx_sample (rx_sample),
        .rx_valid  (rx_valid),
        .fmt       (fmt),
        .fmt_known (fmt_known)
    );

    pcm_tx_ser #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .b_rise    (b_rise),
        .b_high    (b_high),
        .fs_rise   (fs_rise),
        .mute_ok   (mute_ok),
        .known     (fmt_known),
        .fmt       (fmt),
        .tx_sample (tx_sample),
        .tx_take   (tx_take),
        .tx_dout   (tx_dout),
        .tx_oe     (tx_oe)
    );

    assign fmt_long = (fmt == FMT_LONG);

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
    parameter int SAMPLE_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                b_rise,
    input logic                fs_rise,
    input logic                mute_ok,
    input logic                tx_oe,
    input logic                tx_dout,
    input logic                tx_take,
    input logic                rx_valid,
    input logic [SAMPLE_W-1:0] rx_sample,
    input logic                fmt_known
);

    a_r1_known_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_known |=> fmt_known);

    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r3_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take);

    a_r3_dout_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(b_rise) && !$past(fs_rise)) |-> $stable(tx_dout));

    a_r5_oe_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(b_rise) && !$past(fs_rise)) |-> $stable(tx_oe));

    a_r5_oe_needs_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> fmt_known);

    a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(mute_ok)) |-> (rx_sample == '0));

endmodule

bind pcm_serial_port pcm_serial_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
    localparam int CLK_NS = 10;
    localparam int HALF   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, fsync = 1'b0, rx_din = 1'b0, mute_n = 1'b1;
    logic [13:0] tx_sample = 14'h3FFF;
    logic        tx_take, tx_dout, tx_oe, rx_valid, fmt_long, fmt_known;
    logic [13:0] rx_sample;

    always #(CLK_NS/2) clk = ~clk;

    pcm_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rx_din(rx_din),
        .mute_n(mute_n), .tx_sample(tx_sample), .tx_take(tx_take), .tx_dout(tx_dout),
        .tx_oe(tx_oe), .rx_sample(rx_sample), .rx_valid(rx_valid),
        .fmt_long(fmt_long), .fmt_known(fmt_known)
    );

    int          n_chk = 0, n_err = 0, takes = 0;
    bit          bknown = 0, blong = 0, exp_go = 0, exp_mblk = 0;
    int          exp_off = 0;
    logic [15:0] exp_word = '0;
    logic        fs_cur = 1'b0;
    logic [13:0] rxq[$];

    always @(negedge clk) begin
        if (rx_valid) rxq.push_back(rx_sample);
        if (tx_take)  takes++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Captures what the model expects for the frame whose sync just rose.
    task automatic record_rise();
        exp_go   = bknown && mute_n;
        exp_mblk = bknown && !mute_n;
        exp_off  = blong ? 0 : 1;
        exp_word = {tx_sample, 2'b00};
    endtask

    task automatic half(input logic b, input logic fa, input logic fb, input logic rxb,
                        input logic eoe, input logic ebit, input string t_oe);
        bclk = b; fsync = fa; rx_din = rxb;
        for (int k = 1; k <= HALF; k++) begin
            @(negedge clk);
            if (k == 2) fsync = fb;
            if (k >= HALF - 1) begin
                chk(t_oe, tx_oe, eoe);
                if (eoe) chk("R3", tx_dout, ebit);
            end
        end
    endtask

    task automatic frame(input int nb, input int fslen, input bit late, input bit next_early,
                         input logic [13:0] rxw, input logic [1:0] rxpad,
                         input logic [13:0] txnext, input int moff, input int mon);
        logic [15:0] rw;
        bit          islong;
        int          q;
        logic        rxb, eoe, ebit, fa, fb, mexp;
        string       t_oe, t_rx;
        rw     = {rxw, rxpad};
        islong = (fslen >= 2);
        mexp   = 1'b1;
        for (int p = 0; p < nb; p++) begin
            if (p == moff) mute_n = 1'b0;
            if (p == mon)  mute_n = 1'b1;
            if (p == 20)   tx_sample = txnext;
            if (p == 13)   mexp = mute_n;
            q   = islong ? p : p - 1;
            rxb = (q >= 0 && q < 16) ? rw[15-q] : ((p % 2) == 1);
            fa = fs_cur; fb = fs_cur;
            if (p == 0 && late) begin fa = 1'b0; fb = 1'b1; record_rise(); end
            eoe  = exp_go && (p >= exp_off) && (p < exp_off + 16);
            ebit = eoe ? exp_word[15-(p-exp_off)] : 1'b0;
            t_oe = exp_mblk ? "R6" : ((p == exp_off && exp_go) ? "R4" : "R5");
            half(1'b1, fa, fb, rxb, eoe, ebit, t_oe);
            fs_cur = fb;
            fa = fs_cur; fb = fs_cur;
            if (p == fslen - 1) fb = 1'b0;
            if (p == nb - 1 && next_early) fb = 1'b1;
            half(1'b0, fa, fb, rxb, eoe, ebit, t_oe);
            if (p == nb - 1 && next_early) record_rise();
            fs_cur = fb;
            if (p == 2) begin bknown = 1; blong = islong; end
            if (p == 24) begin
                t_rx = !mexp ? "R7" : (fslen >= nb - 2 ? "R8" : (nb == 64 ? "R9" : "R2"));
                chk("R2 strobe count", rxq.size(), 1);
                if (rxq.size() > 0) chk(t_rx, rxq.pop_front(), mexp ? rxw : 14'h0);
                while (rxq.size() > 0) void'(rxq.pop_front());
                chk("R1 fmt_long", fmt_long, islong);
                chk("R1 fmt_known", fmt_known, 1);
            end
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 oe in reset", tx_oe, 0);
        chk("R10 valid in reset", rx_valid, 0);
        chk("R10 known in reset", fmt_known, 0);
        chk("R10 take in reset", tx_take, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            half(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
            half(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        end
        chk("R10 known idle", fmt_known, 0);
        // nb fslen late next_early rx pad txnext moff mon
        frame(32, 4,  1, 1, 14'h0A5C, 2'b11, 14'h1234, -1, -1);
        frame(32, 2,  0, 0, 14'h1FFF, 2'b10, 14'h2000, -1, -1);
        frame(64, 1,  1, 1, 14'h2000, 2'b01, 14'h164A, -1, -1);
        frame(64, 1,  0, 0, 14'h164A, 2'b11, 14'h0000, -1, -1);
        frame(32, 1,  1, 1, 14'h0000, 2'b11, 14'h0F0F, 30, -1);
        frame(32, 3,  0, 0, 14'h2BCD, 2'b10, 14'h3333, -1, 28);
        frame(32, 2,  1, 1, 14'h1111, 2'b01, 14'h2AAA,  5, -1);
        frame(64, 1,  0, 0, 14'h1555, 2'b11, 14'h0123, -1, 20);
        frame(64, 62, 1, 1, 14'h2F0F, 2'b00, 14'h3ABC, -1, -1);
        frame(32, 1,  0, 0, 14'h3001, 2'b10, 14'h0000, -1, -1);
        for (int i = 0; i < 2; i++) begin
            half(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
            half(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        end
        chk("R3 take count", takes, 10);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule